// File: doc/BRIEF.md
# Hamming (7,4) Encoder and Single-Error Corrector

This block holds the two halves of a systematic (7,4) linear block code. The encoder side takes a 4-bit data word. It emits a 7-bit code word made of the data followed by three parity bits. The parity bits come from a fixed generator sub-matrix under modulo-2 arithmetic.

The decoder side takes a received 7-bit word and forms a 3-bit syndrome. It matches a non-zero syndrome against the seven columns of the parity-check matrix. It inverts the bit whose column matched and returns the corrected data word together with two flags. An error flag means the syndrome was non-zero. A fix flag means one of the four data bits was inverted.

Both paths are pure logic followed by one optional output register stage, which is enabled by default. Bit numbering is 1 to 7 from the left. Bit 1 is the most significant bit of each vector: code bit 1 is `[6]` and data bit 1 is `[3]`.

Top module: `ham74_codec`

## Requirements
- R1: The top four bits of `enc_code_o` (`[6:3]`) equal the data word applied to `enc_data_i`.
- R2: The low three code bits are parity bits q1, q2, q3 at `[2]`, `[1]`, `[0]`. With data bits a1..a4 at `enc_data_i[3:0]`: q1 = a1^a2^a3, q2 = a1^a2^a4 and q3 = a1^a3^a4.
- R3: Data 4'b1010 encodes to 7'b1010010.
- R4: A received word with a zero syndrome gives its top four bits on `dec_data_o`, with `dec_err_o`=0 and `dec_fix_o`=0. The syndrome bits are s1 = c1^c2^c3^c5, s2 = c1^c2^c4^c6 and s3 = c1^c3^c4^c7.
- R5: Any valid code word with exactly one data bit (bits 1 to 4) inverted decodes to the original data, with `dec_err_o`=1 and `dec_fix_o`=1.
- R6: A single inverted parity bit (bits 5 to 7) decodes to the original data, with `dec_err_o`=1 and `dec_fix_o`=0.
- R7: The received word 7'b1010110 has syndrome 100. It decodes to data 4'b1010 with `dec_err_o`=1 and `dec_fix_o`=0.
- R8: A double-bit error raises `dec_err_o`=1 and is not flagged apart from a single error. The bit whose column equals the syndrome is inverted. The columns for bits 1 to 7 are 111, 110, 101, 011, 100, 010, 001.
- R9: With the default `OUT_REG`=1, every output reflects the inputs of the previous clock edge and does not change between edges. While `rst` is high at an edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| enc_data_i | input | 4 | Data word to encode, bit 1 at [3] |
| enc_code_o | output | 7 | Code word, data in [6:3], parity in [2:0] |
| dec_code_i | input | 7 | Received word to check and correct |
| dec_data_o | output | 4 | Corrected data word |
| dec_err_o | output | 1 | Syndrome was non-zero |
| dec_fix_o | output | 1 | A data bit was inverted by the corrector |

## Verification
A wrong column in the match table does not stay hidden. It shows as a wrong `dec_data_o` or `dec_fix_o` one clock after the single-error pattern at that bit position is applied. A parity equation that is off shows on `enc_code_o` for half of the 16 data words, also one clock later. Every data word is combined with no error, with each single-bit error and with each double-bit error. This exposes every miscorrection or flag fault on the first cycle that exercises it.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
  localparam int K = 4;
  localparam int R = 3;
  localparam int N = K + R;

  typedef logic [K-1:0] data_t;
  typedef logic [R-1:0] syn_t;
  typedef logic [N-1:0] code_t;

  // Parity contribution of each data bit, index 0 = data bit 1 (leftmost).
  localparam syn_t PROW [K] = '{3'b111, 3'b110, 3'b101, 3'b011};

  // Column of the check matrix for position pos (0 = leftmost code bit).
  function automatic syn_t col_of(input int pos);
    syn_t c;
    if (pos < K) c = PROW[pos];
    else         c = syn_t'(1) << (N - 1 - pos);
    return c;
  endfunction

  // Vector index holding position pos.
  function automatic int vidx(input int pos);
    return N - 1 - pos;
  endfunction
endpackage

// File: rtl/ham74_enc.sv
module ham74_enc
  import ham74_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  syn_t par;

  always_comb begin
    par = '0;
    for (int i = 0; i < K; i++) begin
      if (data_i[K-1-i]) par = par ^ PROW[i];
    end
  end

  assign code_o = {data_i, par};
endmodule

// File: rtl/ham74_syn.sv
module ham74_syn
  import ham74_pkg::*;
(
  input  code_t code_i,
  output syn_t  syn_o
);
  always_comb begin
    syn_o = '0;
    for (int p = 0; p < N; p++) begin
      if (code_i[vidx(p)]) syn_o = syn_o ^ col_of(p);
    end
  end
endmodule

// File: rtl/ham74_fix.sv
module ham74_fix
  import ham74_pkg::*;
(
  input  code_t code_i,
  input  syn_t  syn_i,
  output code_t flip_o,
  output data_t data_o,
  output logic  err_o,
  output logic  fix_o
);
  code_t fixed;

  for (genvar p = 0; p < N; p++) begin : g_match
    assign flip_o[vidx(p)] = (syn_i != '0) && (syn_i == col_of(p));
  end

  assign fixed  = code_i ^ flip_o;
  assign data_o = fixed[N-1 -: K];
  assign err_o  = |syn_i;
  assign fix_o  = |flip_o[N-1 -: K];
endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
  import ham74_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] enc_data_i,
  output logic [6:0] enc_code_o,
  input  logic [6:0] dec_code_i,
  output logic [3:0] dec_data_o,
  output logic       dec_err_o,
  output logic       dec_fix_o
);
  code_t enc_c;
  syn_t  syn;
  code_t flip;
  data_t dat_c;
  logic  err_c, fix_c;

  ham74_enc u_enc (.data_i(enc_data_i), .code_o(enc_c));
  ham74_syn u_syn (.code_i(dec_code_i), .syn_o(syn));
  ham74_fix u_fix (.code_i(dec_code_i), .syn_i(syn), .flip_o(flip),
                   .data_o(dat_c), .err_o(err_c), .fix_o(fix_c));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        enc_code_o <= '0;
        dec_data_o <= '0;
        dec_err_o  <= 1'b0;
        dec_fix_o  <= 1'b0;
      end else begin
        enc_code_o <= enc_c;
        dec_data_o <= dat_c;
        dec_err_o  <= err_c;
        dec_fix_o  <= fix_c;
      end
    end

    p_systematic_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> enc_code_o[6:3] == $past(enc_data_i));
  end else begin : g_comb
    assign enc_code_o = enc_c;
    assign dec_data_o = dat_c;
    assign dec_err_o  = err_c;
    assign dec_fix_o  = fix_c;
  end

  p_fix_needs_err_r6: assert property (@(posedge clk) disable iff (rst)
    dec_fix_o |-> dec_err_o);
  p_one_flip_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flip));
  p_clean_no_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (syn == '0) |-> (flip == '0));
  p_nonzero_flips_r8: assert property (@(posedge clk) disable iff (rst)
    (syn != '0) |-> ($countones(flip) == 1));
endmodule

// File: tb/sim_ham74_codec.sv
module sim_ham74_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] enc_data_i = 4'h0;
  logic [6:0] enc_code_o;
  logic [6:0] dec_code_i = 7'h0;
  logic [3:0] dec_data_o;
  logic       dec_err_o, dec_fix_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ham74_codec u0 (.clk(clk), .rst(rst), .enc_data_i(enc_data_i),
    .enc_code_o(enc_code_o), .dec_code_i(dec_code_i),
    .dec_data_o(dec_data_o), .dec_err_o(dec_err_o), .dec_fix_o(dec_fix_o));

  function automatic logic [6:0] m_enc(logic [3:0] d);
    logic a1, a2, a3, a4;
    {a1, a2, a3, a4} = d;
    return {d, a1 ^ a2 ^ a3, a1 ^ a2 ^ a4, a1 ^ a3 ^ a4};
  endfunction

  // Behavioural decoder built from the column list of R8.
  task automatic m_dec(input logic [6:0] c, output logic [3:0] d,
                       output logic e, output logic f);
    int cols [7] = '{7, 6, 5, 3, 4, 2, 1};
    int s;
    logic [6:0] w;
    s = {c[6] ^ c[5] ^ c[4] ^ c[2], c[6] ^ c[5] ^ c[3] ^ c[1],
         c[6] ^ c[4] ^ c[3] ^ c[0]};
    w = c; e = (s != 0); f = 1'b0;
    for (int p = 0; p < 7; p++) begin
      if (s != 0 && cols[p] == s) begin
        w[6-p] = ~w[6-p];
        f = (p < 4);
      end
    end
    d = w[6:3];
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; results are read one full cycle later.
  task automatic run(logic [3:0] d, logic [6:0] c, string tag);
    logic [3:0] xd; logic xe, xf;
    enc_data_i = d;
    dec_code_i = c;
    @(negedge clk);
    m_dec(c, xd, xe, xf);
    check("R1 R2 code", int'(enc_code_o), int'(m_enc(d)));
    check({tag, " data"}, int'(dec_data_o), int'(xd));
    check({tag, " err"},  int'(dec_err_o), int'(xe));
    check({tag, " fix"},  int'(dec_fix_o), int'(xf));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] cw;
    enc_data_i = 4'hF; dec_code_i = 7'h7F;
    repeat (3) @(negedge clk);
    check("R9 reset enc", int'(enc_code_o), 0);
    check("R9 reset data", int'(dec_data_o), 0);
    check("R9 reset flags", int'({dec_err_o, dec_fix_o}), 0);
    rst = 1'b0;

    run(4'b1010, 7'b1010010, "R3 R4");
    check("R3 encode 1010", int'(enc_code_o), int'(7'b1010010));
    run(4'b0000, 7'b1010110, "R7");
    check("R7 data", int'(dec_data_o), int'(4'b1010));
    check("R7 flags", int'({dec_err_o, dec_fix_o}), int'(2'b10));

    // R9: outputs hold between edges after an input change.
    enc_data_i = 4'b0101;
    #1;
    check("R9 hold", int'(enc_code_o), int'(m_enc(4'b0000)));

    for (int d = 0; d < 16; d++) begin
      cw = m_enc(4'(d));
      run(4'(d), cw, "R4");
      for (int p = 0; p < 7; p++) begin
        run(4'(d), cw ^ (7'b1000000 >> p), (p < 4) ? "R5" : "R6");
      end
      for (int i = 0; i < 7; i++) begin
        for (int j = i + 1; j < 7; j++) begin
          run(4'(15 - d), cw ^ (7'b1000000 >> i) ^ (7'b1000000 >> j), "R8");
          check("R8 err raised", int'(dec_err_o), 1);
        end
      end
    end

    rst = 1'b1;
    @(negedge clk);
    check("R9 reset again", int'({enc_code_o, dec_data_o, dec_err_o, dec_fix_o}), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule